// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models the device side of a byte-wide parallel NOR flash. It watches the chip-enable, write-enable and output-enable strobes, sampled on the system clock. From them it forms bus write cycles and decodes keyed multi-cycle unlock sequences. The sequences start a byte program, a sector erase or a whole-array erase, or switch the read path into a product-identification view. The storage is a small register array. The time an operation takes is modelled by a down-counter whose lengths are parameters.

While an operation runs, every read returns a status byte instead of array data. Bit 7 is the data-polling bit, which is the complement of the bit that will finally be stored. Bit 6 is the toggle bit, which inverts after each completed read strobe. A host polls either bit until it sees true data again.

The bus is paced by the strobes alone. There is no valid/ready pair and no back-pressure. The only flow control is the in-band busy status: writes that arrive while an operation runs are dropped, and the host is expected to poll before it issues the next command. All strobes are active low. In this model the tri-stated data bus is split into `dq_out` and its enable `dq_oe`.

Top module: `nor_cmd_engine`

## Requirements
- R1: `dq_oe` is high exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise the outputs are released. An idle read outside identification mode returns the array byte at `addr[MEM_AW-1:0]`.
- R2: A write cycle is the interval in which `ce_n` and `we_n` are both low. The address is taken in the first clock of that interval, which is set by the later of the two falling edges. The data is the value present in the last clock before either strobe rises.
- R3: The writes AA@555h, 55@AAAh, A0@555h followed by a data write to any address program that byte. The new byte is the old byte AND the data, so bits are only ever cleared.
- R4: The writes AA@555h, 55@AAAh, 80@555h, AA@555h, 55@AAAh followed by 30h written to any address set every byte of that address's sector to FFh. The sector is `addr[MEM_AW-1:SECT_AW]`.
- R5: The same five-write prefix followed by 10h written to 555h sets every byte of the array to FFh.
- R6: After a command completes, the block is busy for exactly PROG_CYC, SECT_CYC or CHIP_CYC clock cycles, depending on the operation. While busy, every write is ignored.
- R7: While busy, a read returns bit 7 as the complement of the programmed data's bit 7. During an erase, bit 7 reads 0. In the first cycle after the busy interval ends, even if the read strobe is still held, the read returns true data on all bits.
- R8: While busy, bit 6 starts at 0 when the operation begins and inverts after each read strobe ends. Bits 5..0 read 0, whatever address is read.
- R9: A write that does not match the next step of a sequence returns the decoder to idle and leaves the array unchanged. A new sequence must start again with AA@555h.
- R10: The writes AA@555h, 55@AAAh, 90@555h enter identification mode. In that mode, address 0 reads MFR_CODE, address 1 reads DEV_CODE, and any other address reads the array. Writing F0h to any address leaves the mode and returns the decoder to idle. The one exception is a write of F0h as the data byte of a program.
- R11: After reset the block is idle, not busy and not in identification mode, and every array byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data written by the host |
| dq_out | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Output drive enable for `dq_out` |

## Verification
Two functions can act in the same clock edge: the busy counter reaching zero, and a read whose strobe is already active. The result switches from the status byte to array data without a new strobe. The bench provokes this by lowering the read strobes one cycle before a program finishes and holding them across the end of the busy interval. It expects the complemented bit 7 with bit 6 at 0 in the first sample and the stored byte in the next. The bench also sends a complete program sequence inside a whole-array erase and checks that the target still reads FFh afterwards.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_UNLK2,
    ST_PGM,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3
  } cmd_state_e;

  localparam logic [11:0] KEY_ADDR_A = 12'h555;
  localparam logic [11:0] KEY_ADDR_B = 12'hAAA;

  localparam logic [7:0] KEY_D1    = 8'hAA;
  localparam logic [7:0] KEY_D2    = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ERASE = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_EXIT  = 8'hF0;
endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_active,
  output logic              rd_end
);
  logic wr_act, wr_act_q, rd_act_q;

  assign wr_act    = !ce_n && !we_n;
  assign rd_active = !ce_n && !oe_n && we_n;
  assign wr_strobe = !wr_act && wr_act_q;
  assign rd_end    = !rd_active && rd_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_active;
      // address: first clock in which both strobes are low
      if (wr_act && !wr_act_q) wr_addr <= addr;
      // data: follows the bus until either strobe rises
      if (wr_act) wr_data <= din;
    end
  end

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_act_q) |=> $stable(wr_addr));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              busy,
  output logic              go_prog,
  output logic              go_sect,
  output logic              go_chip,
  output logic              id_mode
);
  cmd_state_e  st, st_n;
  logic        idm_n;
  logic        accept;
  logic        at_a, at_b;
  logic [11:0] key;

  assign accept = wr_strobe && !busy;
  assign key    = wr_addr[11:0];
  assign at_a   = (key == KEY_ADDR_A);
  assign at_b   = (key == KEY_ADDR_B);

  always_comb begin
    st_n    = st;
    idm_n   = id_mode;
    go_prog = 1'b0;
    go_sect = 1'b0;
    go_chip = 1'b0;
    if (accept) begin
      if (wr_data == CMD_EXIT && st != ST_PGM) begin
        st_n  = ST_IDLE;
        idm_n = 1'b0;
      end else begin
        st_n = ST_IDLE;
        unique case (st)
          ST_IDLE:  if (wr_data == KEY_D1 && at_a) st_n = ST_UNLK1;
          ST_UNLK1: if (wr_data == KEY_D2 && at_b) st_n = ST_UNLK2;
          ST_UNLK2: if (at_a) begin
            if (wr_data == CMD_PROG)       st_n  = ST_PGM;
            else if (wr_data == CMD_ERASE) st_n  = ST_ERS1;
            else if (wr_data == CMD_IDENT) idm_n = 1'b1;
          end
          ST_PGM:   go_prog = 1'b1;
          ST_ERS1:  if (wr_data == KEY_D1 && at_a) st_n = ST_ERS2;
          ST_ERS2:  if (wr_data == KEY_D2 && at_b) st_n = ST_ERS3;
          ST_ERS3: begin
            if (wr_data == CMD_SECT)               go_sect = 1'b1;
            else if (wr_data == CMD_CHIP && at_a)  go_chip = 1'b1;
          end
          default:  st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      id_mode <= 1'b0;
    end else begin
      st      <= st_n;
      id_mode <= idm_n;
    end
  end

  assert_exit_ident_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_data == CMD_EXIT && st != ST_PGM) |=> (!id_mode && st == ST_IDLE));

  assert_busy_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(st));
endmodule

// File: rtl/flash_array_ctl.sv
module flash_array_ctl
  import flash_cmd_pkg::*;
#(
  parameter int MEM_AW   = 6,
  parameter int SECT_AW  = 4,
  parameter int PROG_CYC = 6,
  parameter int SECT_CYC = 10,
  parameter int CHIP_CYC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_prog,
  input  logic              go_sect,
  input  logic              go_chip,
  input  logic [MEM_AW-1:0] op_addr,
  input  logic [BYTE_W-1:0] op_data,
  input  logic [MEM_AW-1:0] rd_addr,
  input  logic              rd_end,
  output logic              busy,
  output logic [BYTE_W-1:0] rd_data,
  output logic              poll_bit,
  output logic              tog_bit
);
  localparam int DEPTH   = 1 << MEM_AW;
  localparam int SECT_IW = MEM_AW - SECT_AW;
  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int CNT_MAX = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [BYTE_W-1:0]  mem [DEPTH];
  logic [CNT_W-1:0]   cnt;
  logic [SECT_IW-1:0] sect_sel;
  logic [BYTE_W-1:0]  cur_byte;

  assign busy     = (cnt != '0);
  assign rd_data  = mem[rd_addr];
  assign cur_byte = mem[op_addr];
  assign sect_sel = op_addr[MEM_AW-1:SECT_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      cnt      <= '0;
      poll_bit <= 1'b0;
      tog_bit  <= 1'b0;
    end else if (go_prog) begin
      mem[op_addr] <= cur_byte & op_data;
      cnt          <= CNT_W'(PROG_CYC);
      poll_bit     <= ~op_data[BYTE_W-1];
      tog_bit      <= 1'b0;
    end else if (go_sect) begin
      for (int i = 0; i < DEPTH; i++)
        if ((i >> SECT_AW) == int'(sect_sel)) mem[i] <= '1;
      cnt      <= CNT_W'(SECT_CYC);
      poll_bit <= 1'b0;
      tog_bit  <= 1'b0;
    end else if (go_chip) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      cnt      <= CNT_W'(CHIP_CYC);
      poll_bit <= 1'b0;
      tog_bit  <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (rd_end) tog_bit <= ~tog_bit;
    end
  end

  assert_start_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_prog || go_sect || go_chip) |-> !busy);

  assert_busy_ends_at_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cnt) == CNT_W'(1)));

  assert_prog_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_prog |=> ((mem[$past(op_addr)] & ~$past(cur_byte)) == '0));

  assert_sector_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    go_sect |=> (mem[{$past(sect_sel), {SECT_AW{1'b0}}}] == '1));

  assert_chip_filled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_chip |=> (mem[DEPTH-1] == '1 && mem[0] == '1));
endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          MEM_AW   = 6,
  parameter int          SECT_AW  = 4,
  parameter int          PROG_CYC = 6,
  parameter int          SECT_CYC = 10,
  parameter int          CHIP_CYC = 14,
  parameter logic [7:0]  MFR_CODE = 8'hC5,
  parameter logic [7:0]  DEV_CODE = 8'h3A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dq_in,
  output logic [7:0]        dq_out,
  output logic              dq_oe
);
  localparam int STAT_PAD = BYTE_W - 2;

  logic              wr_strobe, rd_active, rd_end;
  logic [ADDR_W-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;
  logic              go_prog, go_sect, go_chip, id_mode;
  logic              busy, poll_bit, tog_bit;
  logic [BYTE_W-1:0] arr_byte, rd_byte;

  flash_bus_port #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_port (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(dq_in), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_active(rd_active), .rd_end(rd_end)
  );

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .go_prog(go_prog), .go_sect(go_sect),
    .go_chip(go_chip), .id_mode(id_mode)
  );

  flash_array_ctl #(
    .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_arr (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_sect(go_sect),
    .go_chip(go_chip), .op_addr(wr_addr[MEM_AW-1:0]), .op_data(wr_data),
    .rd_addr(addr[MEM_AW-1:0]), .rd_end(rd_end), .busy(busy),
    .rd_data(arr_byte), .poll_bit(poll_bit), .tog_bit(tog_bit)
  );

  always_comb begin
    if (busy)                                 rd_byte = {poll_bit, tog_bit, {STAT_PAD{1'b0}}};
    else if (id_mode && addr == ADDR_W'(0))   rd_byte = MFR_CODE;
    else if (id_mode && addr == ADDR_W'(1))   rd_byte = DEV_CODE;
    else                                      rd_byte = arr_byte;
  end

  assign dq_oe  = rd_active;
  assign dq_out = rd_active ? rd_byte : '0;

  assert_no_drive_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !dq_oe);

  assert_status_low_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> (dq_out[STAT_PAD-1:0] == '0));
endmodule

// File: tb/nor_cmd_engine_bench.sv
module nor_cmd_engine_bench;
  localparam int ADDR_W = 12, MEM_AW = 6, SECT_AW = 4;
  localparam int PROG_CYC = 6, SECT_CYC = 10, CHIP_CYC = 14;
  localparam logic [7:0] MFR = 8'hC5, DEV = 8'h3A;
  localparam int DEPTH = 1 << MEM_AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] dq_in = '0;
  logic [7:0] dq_out;
  logic dq_oe;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] v;

  always #10 clk = ~clk;

  nor_cmd_engine #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .SECT_AW(SECT_AW), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC), .MFR_CODE(MFR), .DEV_CODE(DEV)
  ) u_nor_cmd_engine (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; commit at the 3rd posedge
  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    addr = a; dq_in = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #2 d = dq_out;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic unlock();
    bus_write(12'h555, 8'hAA);
    bus_write(12'hAAA, 8'h55);
  endtask

  task automatic program_byte(input int a, input logic [7:0] d);
    unlock();
    bus_write(12'h555, 8'hA0);
    bus_write(ADDR_W'(a), d);
    model[a] = model[a] & d;
    repeat (PROG_CYC + 1) @(negedge clk);
  endtask

  task automatic erase_prefix();
    unlock();
    bus_write(12'h555, 8'h80);
    unlock();
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(ADDR_W'(i), v);
      chk(req, v, model[i]);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R1 gating
    chk("R11 oe idle", {7'b0, dq_oe}, 8'h00);
    bus_read(12'd5, v);
    chk("R11 erased after reset", v, 8'hFF);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; #2;
    chk("R1 oe_n high releases", {7'b0, dq_oe}, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0; #2;
    chk("R1 ce_n high releases", {7'b0, dq_oe}, 8'h00);
    ce_n = 1'b0; #2;
    chk("R1 both low drives", {7'b0, dq_oe}, 8'h01);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R10 identification
    unlock();
    bus_write(12'h555, 8'h90);
    bus_read(12'd0, v); chk("R10 manufacturer code", v, MFR);
    bus_read(12'd1, v); chk("R10 device code", v, DEV);
    bus_read(12'd2, v); chk("R10 other address reads array", v, model[2]);
    bus_write(12'h123, 8'hF0);
    bus_read(12'd0, v); chk("R10 exit returns array", v, model[0]);

    // R3 program, R7 polling held across completion
    unlock();
    bus_write(12'h555, 8'hA0);
    bus_write(12'd40, 8'h0F);
    model[40] = model[40] & 8'h0F;
    repeat (PROG_CYC - 1) @(negedge clk);
    addr = 12'd40; ce_n = 1'b0; oe_n = 1'b0; #2;
    chk("R7 poll complement during program", dq_out, 8'h80);
    @(negedge clk); #2;
    chk("R7 true data at completion", dq_out, model[40]);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);

    // R2 skewed strobes: later fall sets address, data before rise
    unlock();
    bus_write(12'h555, 8'hA0);
    addr = 12'd7; ce_n = 1'b0;
    @(negedge clk);
    addr = 12'd9; dq_in = 8'h3C; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1; dq_in = 8'h00; addr = 12'd11;
    @(negedge clk);
    ce_n = 1'b1;
    model[9] = model[9] & 8'h3C;
    repeat (PROG_CYC + 1) @(negedge clk);
    bus_read(12'd9, v);  chk("R2 captured address and data", v, model[9]);
    bus_read(12'd7, v);  chk("R2 early address unused", v, model[7]);
    bus_read(12'd11, v); chk("R2 late address unused", v, model[11]);

    // R9 broken sequences
    unlock();
    bus_write(12'd3, 8'h12);
    bus_write(12'h555, 8'hA0);
    bus_write(12'd3, 8'h00);
    bus_read(12'd3, v); chk("R9 broken program leaves array", v, model[3]);
    unlock();
    bus_write(12'h555, 8'h80);
    bus_write(12'h555, 8'hAA);
    bus_write(12'hAAA, 8'h77);
    bus_write(12'h555, 8'h10);
    bus_read(12'd40, v); chk("R9 broken erase leaves array", v, model[40]);

    // R5 chip erase with R8 toggle and R7 erase polling
    erase_prefix();
    bus_write(12'h555, 8'h10);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    bus_read(12'd33, v); chk("R8 first status toggle 0", v, 8'h00);
    bus_read(12'd33, v); chk("R8 second status toggle 1", v, 8'h40);
    bus_read(12'd5, v);  chk("R8 third status any address", v, 8'h00);
    repeat (CHIP_CYC) @(negedge clk);
    bus_read(12'd40, v); chk("R5 erased after chip erase", v, 8'hFF);

    // R6 writes ignored while busy
    erase_prefix();
    bus_write(12'h555, 8'h10);
    unlock();
    bus_write(12'h555, 8'hA0);
    bus_write(12'd20, 8'h00);
    repeat (4) @(negedge clk);
    bus_read(12'd20, v); chk("R6 program during busy ignored", v, 8'hFF);

    // R3 sweep: two passes over every address
    for (int i = 0; i < DEPTH; i++) program_byte(i, 8'((i * 37 + 5) & 255));
    for (int i = 0; i < DEPTH; i++) program_byte(i, 8'((i * 91 + 3) & 255));
    check_all("R3 AND programming sweep");

    // R4 sector erase via address 21 (sector 1)
    erase_prefix();
    bus_write(12'd21, 8'h30);
    for (int i = 0; i < DEPTH; i++)
      if ((i >> SECT_AW) == 1) model[i] = 8'hFF;
    repeat (SECT_CYC + 1) @(negedge clk);
    check_all("R4 sector erase sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule